// File: doc/BRIEF.md
# General-Purpose Event Register Window

This block keeps a set of general-purpose event flags together with a matching set of enable flags, and it raises a level interrupt toward the system controller whenever an enabled flag is pending. Hardware sources outside the block pulse the event inputs. Each pulse latches a status flag. Software reads the flags through a small I/O window and acknowledges them by writing ones. The hotplug logic that produces the events lives outside this block.

The window has a fixed base address and is four bytes long. Its two lower bytes hold the status flags and its two upper bytes hold the enable flags. A host access carries an address, a data word of up to four bytes and a size code. The block breaks the access into one byte per lane in little-endian order. Byte lane k targets address `host_addr + k`. Lanes that fall outside the window are discarded on writes and return zero on reads. Every byte register is written in the same clock edge as the access. The interrupt follows the register state, so it reflects a write or an event from the edge that stores it.

Top module: `gpe_block`

## Requirements
- R1: After reset, every status and enable flag is zero and `sci_irq` is low.
- R2: Only the byte addresses BASE to BASE+3 (BASE = 0xAFE0) belong to the window. A write to any other address changes no flag, and a read of any other address returns zero in that lane.
- R3: `host_size` holds the byte count minus one (0 means 1 byte, 3 means 4 bytes). Lane k, carried in data bits [8k+7:8k], addresses `host_addr + k`. Lanes above the size are inactive. Lanes outside the window are dropped on writes and read as zero.
- R4: Status flag i sits at window byte i/8, bit i%8 (window bytes 0 and 1). It is set at the clock edge where `evt_in[i]` is high.
- R5: Writing 1 to a status bit clears that bit. Writing 0 leaves it unchanged.
- R6: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: Enable flag i sits at window byte 2 + i/8, bit i%8. It takes the written value and keeps it until the next write to that byte.
- R8: `sci_irq` is high exactly when some status flag and its enable flag are both set. It changes only at an edge that carries a write or an event.
- R9: A read returns the current flag values in the same cycle, combinationally, and has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Byte address of lane 0 |
| host_size | input | 2 | Byte count minus one |
| host_wdata | input | 32 | Write data, lane k in bits [8k+7:8k] |
| host_rdata | output | 32 | Read data, same lane layout, zero for inactive lanes |
| evt_in | input | 16 | Event pulses, one per status flag |
| sci_irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the events and the host inputs are stable around each rising edge. They also assume that at most one access arrives per cycle. Under those conditions the state changes only where an event or a decoded lane writes. The stimulus drives every input at the falling edge and withdraws it right after the rising edge, so each access and each event applies on exactly one edge. Random addresses are kept a few bytes either side of the window, so that partial overlaps at both ends appear often.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  // True when byte address a lies within [base, base+len)
  function automatic logic in_window(input logic [31:0] a, input logic [31:0] base,
                                     input logic [31:0] len);
    return (a >= base) && (a < base + len);
  endfunction

  // Next value of one status flag: the event wins over a clearing one
  function automatic logic flag_next(input logic cur, input logic evt, input logic clr);
    return evt | (cur & ~clr);
  endfunction
endpackage

// File: rtl/gpe_lane_decode.sv
module gpe_lane_decode #(
  parameter int AW    = 16,
  parameter int BASE  = 16'hAFE0,
  parameter int WIN   = 4,
  parameter int LANES = 4,
  parameter int SW    = 2,
  parameter int OW    = 2
) (
  input  logic                  req,
  input  logic [AW-1:0]         addr,
  input  logic [SW-1:0]         size,
  output logic [LANES-1:0]      lane_hit,
  output logic [LANES*OW-1:0]   lane_off
);
  import gpe_pkg::*;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [31:0] lane_addr;
    assign lane_addr = 32'(addr) + 32'(k);
    assign lane_hit[k] = req && (32'(size) >= 32'(k)) &&
                         in_window(lane_addr, 32'(BASE), 32'(WIN));
    assign lane_off[k*OW +: OW] = OW'(lane_addr - 32'(BASE));
  end
endmodule

// File: rtl/gpe_byte_steer.sv
module gpe_byte_steer #(
  parameter int WIN   = 4,
  parameter int LANES = 4,
  parameter int OW    = 2
) (
  input  logic                wr,
  input  logic [LANES-1:0]    lane_hit,
  input  logic [LANES*OW-1:0] lane_off,
  input  logic [8*LANES-1:0]  wdata,
  output logic [WIN-1:0]      byte_stb,
  output logic [8*WIN-1:0]    byte_val
);
  always_comb begin
    logic [OW-1:0] off;
    byte_stb = '0;
    byte_val = '0;
    off      = '0;
    for (int k = 0; k < LANES; k++) begin
      off = lane_off[k*OW +: OW];
      if (wr && lane_hit[k]) begin
        byte_stb[off]         = 1'b1;
        byte_val[off*8 +: 8]  = wdata[k*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/gpe_event_regs.sv
module gpe_event_regs #(
  parameter int NB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] evt_in,
  input  logic [NB-1:0] sts_clr,
  input  logic [NB-1:0] en_mask,
  input  logic [NB-1:0] en_val,
  output logic [NB-1:0] sts_q,
  output logic [NB-1:0] en_q
);
  import gpe_pkg::*;

  for (genvar i = 0; i < NB; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sts_q[i] <= 1'b0;
        en_q[i]  <= 1'b0;
      end else begin
        sts_q[i] <= flag_next(sts_q[i], evt_in[i], sts_clr[i]);
        if (en_mask[i]) en_q[i] <= en_val[i];
      end
    end
  end
endmodule

// File: rtl/gpe_block.sv
module gpe_block #(
  parameter int AW    = 16,
  parameter int BASE  = 16'hAFE0,
  parameter int HALF  = 2,
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_req,
  input  logic                 host_wr,
  input  logic [AW-1:0]        host_addr,
  input  logic [1:0]           host_size,
  input  logic [8*LANES-1:0]   host_wdata,
  output logic [8*LANES-1:0]   host_rdata,
  input  logic [8*HALF-1:0]    evt_in,
  output logic                 sci_irq
);
  localparam int WIN = 2 * HALF;
  localparam int NB  = 8 * HALF;
  localparam int OW  = $clog2(WIN);
  localparam int SW  = 2;

  logic [LANES-1:0]    lane_hit;
  logic [LANES*OW-1:0] lane_off;
  logic [WIN-1:0]      byte_stb;
  logic [8*WIN-1:0]    byte_val;
  logic [NB-1:0]       sts_clr;
  logic [NB-1:0]       en_mask;
  logic [NB-1:0]       en_val;
  logic [NB-1:0]       sts_q;
  logic [NB-1:0]       en_q;
  logic [8*WIN-1:0]    win_bytes;
  logic                any_hit;

  gpe_lane_decode #(.AW(AW), .BASE(BASE), .WIN(WIN), .LANES(LANES), .SW(SW), .OW(OW)) u_dec (
    .req(host_req), .addr(host_addr), .size(host_size),
    .lane_hit(lane_hit), .lane_off(lane_off)
  );

  gpe_byte_steer #(.WIN(WIN), .LANES(LANES), .OW(OW)) u_steer (
    .wr(host_wr), .lane_hit(lane_hit), .lane_off(lane_off), .wdata(host_wdata),
    .byte_stb(byte_stb), .byte_val(byte_val)
  );

  for (genvar i = 0; i < NB; i++) begin : g_map
    assign sts_clr[i] = byte_stb[i/8] & byte_val[i];
    assign en_mask[i] = byte_stb[HALF + i/8];
    assign en_val[i]  = byte_val[NB + i];
  end

  gpe_event_regs #(.NB(NB)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .sts_clr(sts_clr),
    .en_mask(en_mask), .en_val(en_val), .sts_q(sts_q), .en_q(en_q)
  );

  assign win_bytes = {en_q, sts_q};
  assign any_hit   = |lane_hit;
  assign sci_irq   = |(sts_q & en_q);

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    logic [OW-1:0] off;
    assign off = lane_off[k*OW +: OW];
    assign host_rdata[k*8 +: 8] = (lane_hit[k] && !host_wr) ? win_bytes[off*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/gpe_block_chk.sv
module gpe_block_chk #(
  parameter int NB = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req,
  input logic          host_wr,
  input logic          any_hit,
  input logic [NB-1:0] evt_in,
  input logic [NB-1:0] sts_clr,
  input logic [NB-1:0] en_mask,
  input logic [NB-1:0] sts,
  input logic [NB-1:0] en,
  input logic          irq
);
  // R4: a pulsed event is latched at the next edge
  a_r4_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((sts & $past(evt_in)) == $past(evt_in)));

  // R6: event beats a simultaneous clear
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_in & sts_clr) != '0) |=> ((sts & $past(evt_in & sts_clr)) == $past(evt_in & sts_clr)));

  // R5: ones written without an event clear the flag
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_clr & ~evt_in) != '0) |=> ((sts & $past(sts_clr & ~evt_in)) == '0));

  // R5: no clear and no event keeps status
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr == '0 && evt_in == '0) |=> $stable(sts));

  // R7: enables move only when their byte is written
  a_r7_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == '0) |=> $stable(en));

  // R2: a write that misses the window changes nothing
  a_r2_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_wr && !any_hit && evt_in == '0) |=> ($stable(sts) && $stable(en)));

  // R8: the interrupt moves only after a write or an event
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!(host_req && host_wr) && evt_in == '0) |=> $stable(irq));

  // R9: reads leave the flags alone
  a_r9_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_wr && evt_in == '0) |=> ($stable(sts) && $stable(en)));
endmodule

bind gpe_block gpe_block_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr), .any_hit(any_hit),
  .evt_in(evt_in), .sts_clr(sts_clr), .en_mask(en_mask), .sts(sts_q), .en(en_q),
  .irq(sci_irq)
);

// File: tb/tb_gpe_block.sv
`timescale 1ns/1ps
module tb_gpe_block;
  localparam int BASE = 16'hAFE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [15:0] evt_in = '0;
  logic        sci_irq;

  int errors = 0;
  int checks = 0;
  logic [15:0] m_sts = '0;
  logic [15:0] m_en = '0;
  bit done = 0;

  always #4 clk = ~clk;

  gpe_block dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .evt_in(evt_in), .sci_irq(sci_irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [15:0] a, input logic [1:0] sz);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int la = int'(a) + k;
      if (k <= int'(sz) && la >= BASE && la < BASE + 4) begin
        int off = la - BASE;
        r[k*8 +: 8] = (off < 2) ? m_sts[off*8 +: 8] : m_en[(off-2)*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic step(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic [15:0] ev, input string tag);
    logic [15:0] clr = '0;
    logic [15:0] en_n = m_en;
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_size = sz;
    host_wdata = d; evt_in = ev;
    #1;
    if (!wr) chk(host_rdata, exp_read(a, sz), tag);
    if (wr) begin
      for (int k = 0; k < 4; k++) begin
        int la = int'(a) + k;
        if (k <= int'(sz) && la >= BASE && la < BASE + 4) begin
          int off = la - BASE;
          if (off < 2) clr[off*8 +: 8] = d[k*8 +: 8];
          else en_n[(off-2)*8 +: 8] = d[k*8 +: 8];
        end
      end
    end
    @(posedge clk);
    m_sts = ev | (m_sts & ~clr);
    m_en  = en_n;
    #1;
    host_req = 1'b0; evt_in = '0;
    chk({31'b0, sci_irq}, {31'b0, |(m_sts & m_en)}, {tag, "/R8"});
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, input string tag);
    step(1'b0, a, sz, 32'h0, 16'h0, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk({31'b0, sci_irq}, 32'h0, "R1 irq");
    rd(BASE, 2'd3, "R1 all zero");
    // R4: event sets status bit 3 and bit 12
    step(1'b0, BASE, 2'd3, 0, 16'h1008, "R4 evt");
    rd(BASE, 2'd1, "R4 status read");
    // R8: enabling bit 12 raises irq
    step(1'b1, BASE + 3, 2'd0, 32'h10, 16'h0, "R7 en write");
    chk({31'b0, sci_irq}, 32'h1, "R8 irq high");
    rd(BASE + 2, 2'd1, "R7 en read");
    // R5: write zero no effect, then clear
    step(1'b1, BASE, 2'd1, 32'h0000, 16'h0, "R5 zero write");
    rd(BASE, 2'd1, "R5 unchanged");
    step(1'b1, BASE + 1, 2'd0, 32'h10, 16'h0, "R5 clear");
    chk({31'b0, sci_irq}, 32'h0, "R8 irq low after clear");
    rd(BASE, 2'd1, "R5 cleared");
    // R6: event beats clear on bit 3
    step(1'b1, BASE, 2'd0, 32'h08, 16'h0008, "R6 race");
    rd(BASE, 2'd0, "R6 bit still set");
    // R3: unaligned 4-byte write at BASE+2: only enable bytes take effect
    step(1'b1, BASE + 2, 2'd3, 32'hAABBCCDD, 16'h0, "R3 tail write");
    rd(BASE, 2'd3, "R3 tail read");
    // R3: access at BASE-1, lane1 maps to byte 0
    rd(BASE - 1, 2'd1, "R3 head read");
    step(1'b1, BASE - 1, 2'd1, 32'hFF00, 16'h0, "R3 head clear");
    rd(BASE, 2'd3, "R3 after head");
    // R2: outside window
    step(1'b1, BASE + 4, 2'd3, 32'hFFFFFFFF, 16'h0, "R2 miss write");
    rd(BASE + 4, 2'd3, "R2 miss read");
    rd(BASE, 2'd3, "R2 state kept");
    // R9: repeated reads have no effect
    step(1'b0, BASE, 2'd3, 0, 16'h00F0, "R9 setup");
    rd(BASE, 2'd3, "R9 read1");
    rd(BASE, 2'd3, "R9 read2");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a = 16'(BASE - 3 + ($urandom % 8));
      logic [1:0]  sz = 2'($urandom % 4);
      logic        w = 1'($urandom % 2);
      logic [15:0] ev = 16'($urandom & $urandom & $urandom);
      step(w, a, sz, $urandom, ev, "R3/R9 random");
    end
    rd(BASE, 2'd3, "R4 final");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule